// File: doc/BRIEF.md
# Two-Wire Bus Target with Broadcast Write

This block is the target side of a two-wire serial bus (I2C). It samples SCL and SDA with a fast system clock after passing them through synchronizers. It finds START and STOP conditions and shifts in the address byte. If the byte names the block's own 7-bit address, the block takes part in the transfer. It also takes part when the byte carries the all-zero broadcast address with the write direction.

In a write, each received byte goes to the user logic with a one-cycle strobe. The user logic can refuse bytes. In a read, the block asks for each byte with a request that stays up until the user answers with a ready pulse and the byte. The block then shifts that byte onto SDA. A bus-busy flag reports whether the bus is inside a transfer.

SDA is never driven high. The block only pulls it low or releases it. The output `sda_pull` is meant for an open-drain pad.

Top module: `i2c_gc_target`

## Requirements
- R1: `bus_busy` is 0 after reset. It goes to 1 after a START, which is SDA falling while SCL is high. It goes back to 0 after a STOP, which is SDA rising while SCL is high. A repeated START leaves it at 1.
- R2: The first byte after a START is 7 address bits, MSB first, then a direction bit (1 = read). When the address equals `OWN_ADDR`, the block acknowledges by pulling SDA low during the 9th SCL clock.
- R3: When the address byte names another target, the block leaves SDA released until the next START. It also delivers no byte for that transfer.
- R4: Address 0000000 with direction 0 (broadcast write) is acknowledged. Each data byte of that transfer is delivered with `rx_gcall` = 1. Bytes of an own-address write are delivered with `rx_gcall` = 0.
- R5: Address 0000000 with direction 1 is not acknowledged. SDA stays released during that whole transfer.
- R6: In a write, the 8 data bits are taken MSB first on SCL rising edges. While `rx_accept` is 1, the byte appears on `rx_data` with `rx_valid` high for one clock cycle, and it is acknowledged on the 9th clock.
- R7: If `rx_accept` is 0 when a write byte completes, the byte is not acknowledged and not delivered. Every later byte before the next START is also ignored and not acknowledged.
- R8: In a read, `tx_req` rises after the address is accepted and after each controller ACK. It stays high until `tx_ready` is seen, which latches `tx_data`. The byte is then driven MSB first, with a new bit after each SCL falling edge, and SDA is released on the 9th clock.
- R9: A NACK from the controller (SDA high on the 9th clock of a read byte) ends the read. No further `tx_req` is raised and SDA stays released until the next START.
- R10: `sda_pull` (1 = hold SDA low) changes only while SCL is low.
- R11: A repeated START in mid-transfer, including in the middle of a byte, restarts address reception from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level seen at the pad |
| sda_in | input | 1 | SDA level seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| bus_busy | output | 1 | High between START and STOP |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_gcall | output | 1 | Byte came from a broadcast write |
| rx_accept | input | 1 | User can take the next write byte |
| tx_req | output | 1 | Block needs the next read byte |
| tx_ready | input | 1 | `tx_data` is valid; completes the request |
| tx_data | input | 8 | Read byte from the user |

## Verification
The assertions assume a well-behaved controller. SDA changes only while SCL is low, except for START and STOP. Each SCL level lasts far longer than the synchronizer delay. The controller never issues a START or STOP while the target is holding SDA low. The stimulus keeps to these rules by construction. Every bus phase lasts 20 system clocks. SDA is changed in the same cycle as the SCL fall or in the middle of the low phase. START and STOP are only issued after the target has released SDA on the 9th clock or after a controller NACK.

// File: rtl/i2c_gc_target.sv
module i2c_gc_target #(
  parameter logic [6:0] OWN_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       bus_busy,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_gcall,
  input  logic       rx_accept,
  output logic       tx_req,
  input  logic       tx_ready,
  input  logic [7:0] tx_data
);

  localparam int SM = SYNC_STAGES - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_WAIT
  } st_t;

  logic [SM:0] scl_sync, sda_sync;
  logic        scl_q, sda_q;
  st_t         st;
  logic [3:0]  bitcnt;
  logic [7:0]  sh, tx_sh, tx_buf;
  logic        rd_dir, gc, ack_seen, tx_have;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SM-1:0], scl_in};
      sda_sync <= {sda_sync[SM-1:0], sda_in};
      scl_q    <= scl_sync[SM];
      sda_q    <= sda_sync[SM];
    end

  wire scl_s     = scl_sync[SM];
  wire sda_s     = sda_sync[SM];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire addr_hit  = (sh[7:1] == OWN_ADDR);
  wire gc_hit    = (sh[7:1] == 7'd0) && !sh[0];
  wire hs        = tx_req & tx_ready;
  wire quiet     = (st == S_IDLE) || (st == S_WAIT);
  wire [7:0] next_tx = tx_have ? tx_buf : (hs ? tx_data : 8'hFF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      tx_sh    <= '1;
      tx_buf   <= '0;
      tx_have  <= 1'b0;
      rd_dir   <= 1'b0;
      gc       <= 1'b0;
      ack_seen <= 1'b0;
      sda_pull <= 1'b0;
      bus_busy <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_gcall <= 1'b0;
      tx_req   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (hs) begin
        tx_buf  <= tx_data;
        tx_have <= 1'b1;
        tx_req  <= 1'b0;
      end
      if (start_det || stop_det) begin
        st       <= start_det ? S_ADDR : S_IDLE;
        bus_busy <= start_det;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        tx_req   <= 1'b0;
        tx_have  <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_ADDR, S_WDATA: begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          S_RDATA: bitcnt <= bitcnt + 4'd1;
          S_RACK:
            if (!sda_s) begin
              ack_seen <= 1'b1;
              tx_req   <= 1'b1;
            end else st <= S_WAIT;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_ADDR:
            if (bitcnt == 4'd8) begin
              if (addr_hit || gc_hit) begin
                st       <= S_AACK;
                sda_pull <= 1'b1;
                rd_dir   <= sh[0];
                gc       <= gc_hit;
                if (sh[0]) tx_req <= 1'b1;
              end else st <= S_WAIT;
            end
          S_AACK: begin
            bitcnt <= '0;
            if (rd_dir) begin
              tx_sh    <= next_tx;
              sda_pull <= ~next_tx[7];
              tx_have  <= 1'b0;
              tx_req   <= 1'b0;
              st       <= S_RDATA;
            end else begin
              sda_pull <= 1'b0;
              st       <= S_WDATA;
            end
          end
          S_WDATA:
            if (bitcnt == 4'd8) begin
              if (rx_accept) begin
                rx_data  <= sh;
                rx_valid <= 1'b1;
                rx_gcall <= gc;
                sda_pull <= 1'b1;
                st       <= S_WACK;
              end else st <= S_WAIT;
            end
          S_WACK: begin
            sda_pull <= 1'b0;
            bitcnt   <= '0;
            st       <= S_WDATA;
          end
          S_RDATA:
            if (bitcnt == 4'd8) begin
              sda_pull <= 1'b0;
              ack_seen <= 1'b0;
              st       <= S_RACK;
            end else if (bitcnt != 4'd0) begin
              sda_pull <= ~tx_sh[6];
              tx_sh    <= {tx_sh[6:0], 1'b1};
            end
          S_RACK:
            if (ack_seen) begin
              tx_sh    <= next_tx;
              sda_pull <= ~next_tx[7];
              tx_have  <= 1'b0;
              tx_req   <= 1'b0;
              bitcnt   <= '0;
              st       <= S_RDATA;
            end
          default: ;
        endcase
      end
    end

endmodule

// File: rtl/i2c_gc_target_chk.sv
module i2c_gc_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic start_det,
  input logic stop_det,
  input logic bus_busy,
  input logic sda_pull,
  input logic rx_valid,
  input logic quiet
);

  // R1
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy);

  // R1
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy);

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_in);

  // R3
  quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_pull);

endmodule

bind i2c_gc_target i2c_gc_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .start_det(start_det),
  .stop_det(stop_det), .bus_busy(bus_busy), .sda_pull(sda_pull),
  .rx_valid(rx_valid), .quiet(quiet)
);

// File: tb/i2c_gc_target_tb.sv
module i2c_gc_target_tb_top;
  localparam int H = 20;
  localparam logic [6:0] ADDR = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_scl_low = 1'b0, ctl_sda_low = 1'b0;
  logic sda_pull, bus_busy, rx_valid, rx_gcall, tx_req;
  logic [7:0] rx_data;
  logic rx_accept = 1'b1, tx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  wire scl = ~ctl_scl_low;
  wire sda = ~(ctl_sda_low | sda_pull);

  int checks = 0, errors = 0;
  logic [8:0] exp_rx[$];
  logic [7:0] tx_q[$];

  always #4 clk = ~clk;

  i2c_gc_target #(.OWN_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .sda_pull(sda_pull),
    .bus_busy(bus_busy), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_gcall(rx_gcall), .rx_accept(rx_accept), .tx_req(tx_req),
    .tx_ready(tx_ready), .tx_data(tx_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    ctl_sda_low = 1'b0; wt(H);
    ctl_scl_low = 1'b0; wt(H);
    ctl_sda_low = 1'b1; wt(H);
    ctl_scl_low = 1'b1; wt(H);
  endtask

  task automatic bus_stop();
    ctl_sda_low = 1'b1; wt(H);
    ctl_scl_low = 1'b0; wt(H);
    ctl_sda_low = 1'b0; wt(H);
  endtask

  task automatic put_bit(input bit b);
    ctl_sda_low = ~b; wt(H);
    ctl_scl_low = 1'b0; wt(H);
    ctl_scl_low = 1'b1;
  endtask

  task automatic get_bit(output bit b);
    ctl_sda_low = 1'b0; wt(H);
    ctl_scl_low = 1'b0; wt(H / 2);
    b = sda;
    wt(H / 2);
    ctl_scl_low = 1'b1;
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(s);
    ack = ~s;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit nack);
    bit s;
    for (int i = 7; i >= 0; i--) begin get_bit(s); d[i] = s; end
    put_bit(nack);
  endtask

  // scoreboard monitor for received bytes (R6, R4)
  always @(negedge clk)
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) chk(1'b0, "R6 unexpected byte", {rx_gcall, rx_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_rx.pop_front();
        chk({rx_gcall, rx_data} == e, "R6/R4 rx byte", {rx_gcall, rx_data}, e);
      end
    end

  // user side for read requests (R8)
  initial forever begin
    @(negedge clk);
    if (tx_req && !tx_ready) begin
      wt(3);
      tx_data  = tx_q.size() != 0 ? tx_q.pop_front() : 8'h00;
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
  end

  initial begin
    wt(150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    wt(5);
    chk(bus_busy == 0 && sda_pull == 0, "R1 reset idle", {bus_busy, sda_pull}, 0);
    chk(rx_valid == 0 && tx_req == 0, "R8 reset strobes", {rx_valid, tx_req}, 0);
    rst_n = 1'b1;
    wt(5);

    // own-address write
    bus_start();
    chk(bus_busy == 1, "R1 busy after START", bus_busy, 1);
    put_byte({ADDR, 1'b0}, ack);
    chk(ack == 1, "R2 own address ack", ack, 1);
    exp_rx.push_back({1'b0, 8'hA5});
    put_byte(8'hA5, ack);
    chk(ack == 1, "R6 data ack", ack, 1);
    exp_rx.push_back({1'b0, 8'h3C});
    put_byte(8'h3C, ack);
    chk(ack == 1, "R6 second data ack", ack, 1);
    bus_stop();
    wt(5);
    chk(bus_busy == 0, "R1 idle after STOP", bus_busy, 0);

    // other target
    bus_start();
    put_byte({7'h11, 1'b0}, ack);
    chk(ack == 0, "R3 foreign address nack", ack, 0);
    put_byte(8'h99, ack);
    chk(ack == 0, "R3 foreign data ignored", ack, 0);
    bus_stop();

    // broadcast write
    bus_start();
    put_byte(8'h00, ack);
    chk(ack == 1, "R4 broadcast write ack", ack, 1);
    exp_rx.push_back({1'b1, 8'h5A});
    put_byte(8'h5A, ack);
    chk(ack == 1, "R4 broadcast data ack", ack, 1);
    bus_stop();

    // broadcast read
    bus_start();
    put_byte(8'h01, ack);
    chk(ack == 0, "R5 broadcast read nack", ack, 0);
    wt(3 * H);
    chk(sda_pull == 0 && tx_req == 0, "R5 stays released", {sda_pull, tx_req}, 0);
    bus_stop();

    // user refuses bytes
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    chk(ack == 1, "R2 address ack", ack, 1);
    rx_accept = 1'b0;
    put_byte(8'h12, ack);
    chk(ack == 0, "R7 refused byte nack", ack, 0);
    rx_accept = 1'b1;
    put_byte(8'h34, ack);
    chk(ack == 0, "R7 later byte ignored", ack, 0);
    bus_stop();

    // read
    tx_q.push_back(8'hC3); tx_q.push_back(8'h81); tx_q.push_back(8'h7E);
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(ack == 1, "R2 read address ack", ack, 1);
    get_byte(d, 1'b0);
    chk(d == 8'hC3, "R8 first read byte", d, 8'hC3);
    get_byte(d, 1'b0);
    chk(d == 8'h81, "R8 second read byte", d, 8'h81);
    get_byte(d, 1'b1);
    chk(d == 8'h7E, "R8 third read byte", d, 8'h7E);
    wt(4 * H);
    chk(tx_req == 0 && sda_pull == 0, "R9 read ended by nack", {tx_req, sda_pull}, 0);
    chk(tx_q.size() == 0, "R9 bytes consumed", tx_q.size(), 0);
    bus_stop();

    // repeated START between packets
    tx_q.push_back(8'h42);
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    exp_rx.push_back({1'b0, 8'h66});
    put_byte(8'h66, ack);
    chk(ack == 1, "R6 byte before restart", ack, 1);
    bus_start();
    chk(bus_busy == 1, "R1 busy kept on repeated START", bus_busy, 1);
    put_byte({ADDR, 1'b1}, ack);
    chk(ack == 1, "R11 address after restart", ack, 1);
    get_byte(d, 1'b1);
    chk(d == 8'h42, "R11 read after restart", d, 8'h42);
    bus_stop();

    // repeated START inside a byte
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    chk(ack == 1, "R11 address after mid-byte restart", ack, 1);
    exp_rx.push_back({1'b0, 8'h0F});
    put_byte(8'h0F, ack);
    chk(ack == 1, "R11 byte after mid-byte restart", ack, 1);
    bus_stop();
    wt(10);
    chk(exp_rx.size() == 0, "R6 all bytes delivered", exp_rx.size(), 0);
    chk(sda_pull == 0 && bus_busy == 0, "R10 released at end", {sda_pull, bus_busy}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule